// File: doc/BRIEF.md
# Network Address Selection Controller

This block runs once after reset and settles which Ethernet MAC address and which IPv4 address the device uses. It first requests a user configuration record from nonvolatile storage. A record counts as present only when its 16-bit signature word equals a fixed constant. The record also carries a MAC address, a static IPv4 address and a flag asking for a dynamically assigned address.

When a record is missing, or when it asks for a dynamic address, the controller raises a request to an external DHCP engine. It then waits until the engine grants an address, reports an error, or a programmable cycle budget runs out. A failed attempt falls back to a different address in each case. With a good record the fallback is the stored static address. Without one it is a hardwired default. Once the choice is made the controller raises a done flag. It holds the chosen addresses and a two-bit code telling where the IP came from, and ignores its inputs from then on.

Top module: `net_addr_select`

## Requirements
- R1: While reset is held, `done` and `dhcp_req` are 0. After reset is released, `rec_req` is 1 until `rec_ack` is seen.
- R2: When the record signature equals 16'h5AFE, `mac_o` is the record MAC. Otherwise `mac_o` is 48'h0007ED012345.
- R3: With a good record and the DHCP flag clear, `ip_o` is the record IP and `src_o` is 1 (static). `dhcp_req` is never raised.
- R4: With a good record and the DHCP flag set, `dhcp_req` is raised. A grant makes `ip_o` the granted address and `src_o` 0 (DHCP).
- R5: With a good record, the DHCP flag set and a failed request, `ip_o` is the record IP and `src_o` is 1.
- R6: Without a good record, `dhcp_req` is raised whatever the flag. A grant makes `ip_o` the granted address and `src_o` 0.
- R7: Without a good record and with a failed request, `ip_o` is 32'hC0A80119 and `src_o` is 2 (default).
- R8: With neither grant nor error, `dhcp_req` stays high for exactly `timeout_lim`+1 cycles, and the request then fails. A grant in the last of those cycles is still accepted.
- R9: An error ends the wait as a failure, with `dhcp_req` dropping after the cycle in which the error is sampled. A grant in the same cycle as an error wins.
- R10: `done` rises once after reset and stays high. From then on `mac_o`, `ip_o` and `src_o` are stable, `rec_req` and `dhcp_req` are 0, and later record, grant or error inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_req | output | 1 | Asks storage for the configuration record |
| rec_ack | input | 1 | Record fields are valid this cycle |
| rec_sig | input | 16 | Record signature word |
| rec_mac | input | 48 | Record MAC address |
| rec_ip | input | 32 | Record static IPv4 address |
| rec_dhcp | input | 1 | Record asks for a dynamic address |
| timeout_lim | input | CW | DHCP wait budget, in cycles minus one |
| dhcp_req | output | 1 | Lease request to the DHCP engine, high while waiting |
| dhcp_grant | input | 1 | Engine granted an address |
| dhcp_ip | input | 32 | Granted address, valid with `dhcp_grant` |
| dhcp_err | input | 1 | Engine reports failure |
| mac_o | output | 48 | Chosen MAC address |
| ip_o | output | 32 | Chosen IPv4 address |
| src_o | output | 2 | IP origin: 0 DHCP, 1 static, 2 default |
| done | output | 1 | Selection complete |

## Verification
The bench targets the edges of the wait window. It sends a grant in the very cycle the budget expires, and an error together with a grant. An off-by-one counter would then drop a valid lease or stretch the request by a cycle, and a reversed priority would report a failure although an address was granted. It runs a record whose signature is close to the constant but wrong, and a good record with the flag clear. Here a design that mixed up the two fallbacks would show the default IP with a stored MAC, or would send a request it should never make. After `done` it keeps driving grants and new record fields, so a controller that re-entered its wait or reloaded its outputs shows changed addresses.

// File: rtl/net_addr_select.sv
module net_addr_select #(
  parameter int          CW      = 8,
  parameter logic [15:0] SIG     = 16'h5AFE,
  parameter logic [47:0] DEF_MAC = 48'h0007ED012345,
  parameter logic [31:0] DEF_IP  = 32'hC0A80119
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rec_req,
  input  logic          rec_ack,
  input  logic [15:0]   rec_sig,
  input  logic [47:0]   rec_mac,
  input  logic [31:0]   rec_ip,
  input  logic          rec_dhcp,
  input  logic [CW-1:0] timeout_lim,
  output logic          dhcp_req,
  input  logic          dhcp_grant,
  input  logic [31:0]   dhcp_ip,
  input  logic          dhcp_err,
  output logic [47:0]   mac_o,
  output logic [31:0]   ip_o,
  output logic [1:0]    src_o,
  output logic          done
);
  typedef enum logic [1:0] {S_READ, S_WAIT, S_HOLD} st_t;
  localparam logic [1:0] SRC_DHCP = 2'd0, SRC_STAT = 2'd1, SRC_DEF = 2'd2;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          good_q;
  logic [31:0]   sip_q;

  wire sig_ok  = (rec_sig == SIG);
  wire expired = (cnt == timeout_lim);

  assign rec_req  = (st == S_READ);
  assign dhcp_req = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_READ;
      cnt    <= '0;
      good_q <= 1'b0;
      sip_q  <= '0;
      mac_o  <= '0;
      ip_o   <= '0;
      src_o  <= SRC_DHCP;
      done   <= 1'b0;
    end else begin
      case (st)
        S_READ: if (rec_ack) begin
          good_q <= sig_ok;
          sip_q  <= rec_ip;
          mac_o  <= sig_ok ? rec_mac : DEF_MAC;
          cnt    <= '0;
          if (sig_ok && !rec_dhcp) begin
            ip_o  <= rec_ip;
            src_o <= SRC_STAT;
            done  <= 1'b1;
            st    <= S_HOLD;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (dhcp_grant) begin
            ip_o  <= dhcp_ip;
            src_o <= SRC_DHCP;
            done  <= 1'b1;
            st    <= S_HOLD;
          end else if (dhcp_err || expired) begin
            ip_o  <= good_q ? sip_q : DEF_IP;
            src_o <= good_q ? SRC_STAT : SRC_DEF;
            done  <= 1'b1;
            st    <= S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/net_addr_select_chk.sv
module net_addr_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rec_req,
  input logic        dhcp_req,
  input logic        dhcp_grant,
  input logic        dhcp_err,
  input logic [47:0] mac_o,
  input logic [31:0] ip_o,
  input logic [1:0]  src_o,
  input logic        done
);
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n) !(rec_req && dhcp_req)); // R1
  AST_DEF_MAC: assert property (@(posedge clk) disable iff (!rst_n) (done && src_o == 2'd2) |-> mac_o == 48'h0007ED012345); // R2
  AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (dhcp_req && dhcp_grant) |=> (done && src_o == 2'd0)); // R4
  AST_DEF_IP: assert property (@(posedge clk) disable iff (!rst_n) (done && src_o == 2'd2) |-> ip_o == 32'hC0A80119); // R7
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (dhcp_req && dhcp_err) |=> (done && !dhcp_req)); // R9
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R10
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) done |=> ($stable(mac_o) && $stable(ip_o) && $stable(src_o))); // R10
  AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!rec_req && !dhcp_req && src_o != 2'd3)); // R10
endmodule

bind net_addr_select net_addr_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rec_req(rec_req), .dhcp_req(dhcp_req),
  .dhcp_grant(dhcp_grant), .dhcp_err(dhcp_err), .mac_o(mac_o), .ip_o(ip_o),
  .src_o(src_o), .done(done)
);

// File: tb/net_addr_select_test.sv
module net_addr_select_test;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_ack = 1'b0, rec_dhcp = 1'b0, dhcp_grant = 1'b0, dhcp_err = 1'b0;
  logic [15:0] rec_sig = '0;
  logic [47:0] rec_mac = '0;
  logic [31:0] rec_ip = '0, dhcp_ip = '0;
  logic [CW-1:0] timeout_lim = '0;
  logic rec_req, dhcp_req, done;
  logic [47:0] mac_o;
  logic [31:0] ip_o;
  logic [1:0] src_o;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  net_addr_select #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .rec_req(rec_req), .rec_ack(rec_ack), .rec_sig(rec_sig),
    .rec_mac(rec_mac), .rec_ip(rec_ip), .rec_dhcp(rec_dhcp), .timeout_lim(timeout_lim),
    .dhcp_req(dhcp_req), .dhcp_grant(dhcp_grant), .dhcp_ip(dhcp_ip), .dhcp_err(dhcp_err),
    .mac_o(mac_o), .ip_o(ip_o), .src_o(src_o), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string ip_tag(input bit good, input bit den, input bit granted);
    if (good && !den) return "R3";
    if (good) return granted ? "R4" : "R5";
    return granted ? "R6" : "R7";
  endfunction

  // mode: 0 silent engine, 1 grant at wait index k, 2 error at k, 3 grant and error at k
  task automatic run(input logic [15:0] sig, input logic [47:0] mac, input logic [31:0] sip,
                     input bit den, input logic [CW-1:0] lim, input int mode, input int k,
                     input logic [31:0] gip);
    bit good = (sig == 16'h5AFE);
    bit uses = !good || den;
    bit granted = uses && (mode == 1 || mode == 3) && k <= int'(lim);
    bit errored = uses && (mode == 2) && k <= int'(lim);
    int exp_reqs = !uses ? 0 : ((granted || errored) ? k + 1 : int'(lim) + 1);
    logic [47:0] exp_mac = good ? mac : 48'h0007ED012345;
    logic [31:0] exp_ip = !uses ? sip : granted ? gip : good ? sip : 32'hC0A80119;
    logic [1:0] exp_src = granted ? 2'd0 : good ? 2'd1 : 2'd2;
    string t = ip_tag(good, den, granted);
    int reqs = 0;
    logic [47:0] m0; logic [31:0] i0; logic [1:0] s0;
    @(negedge clk);
    rst_n = 1'b0; rec_ack = 1'b0; dhcp_grant = 1'b0; dhcp_err = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && dhcp_req == 1'b0, "R1", {62'd0, done, dhcp_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rec_req == 1'b1, "R1", {63'd0, rec_req}, 64'd1);
    rec_sig = sig; rec_mac = mac; rec_ip = sip; rec_dhcp = den; timeout_lim = lim;
    dhcp_ip = gip; rec_ack = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      rec_ack = 1'b0;
      if (done) break;
      dhcp_grant = 1'b0; dhcp_err = 1'b0;
      if (dhcp_req) begin
        if (reqs == k) begin
          dhcp_grant = (mode == 1 || mode == 3);
          dhcp_err = (mode == 2 || mode == 3);
        end
        reqs++;
      end
    end
    dhcp_grant = 1'b0; dhcp_err = 1'b0;
    chk(done == 1'b1, "R10", {63'd0, done}, 64'd1);
    chk(mac_o == exp_mac, "R2", {16'd0, mac_o}, {16'd0, exp_mac});
    chk(ip_o == exp_ip && src_o == exp_src, t, {30'd0, src_o, ip_o}, {30'd0, exp_src, exp_ip});
    chk(reqs == exp_reqs, !uses ? "R3" : errored ? "R9" : granted ? "R8" : "R8",
        64'(reqs), 64'(exp_reqs));
    m0 = mac_o; i0 = ip_o; s0 = src_o;
    for (int c = 0; c < 4; c++) begin
      rec_ack = 1'b1; rec_sig = 16'h5AFE; rec_mac = ~mac; rec_ip = ~sip;
      dhcp_grant = 1'b1; dhcp_ip = ~gip; dhcp_err = c[0];
      @(negedge clk);
      chk(done && !rec_req && !dhcp_req && mac_o == m0 && ip_o == i0 && src_o == s0, "R10",
          {mac_o[31:0], ip_o}, {m0[31:0], i0});
    end
    rec_ack = 1'b0; dhcp_grant = 1'b0; dhcp_err = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed = $urandom(32'd4242);
    // directed corners
    run(16'h5AFE, 48'h112233445566, 32'h0A000005, 1'b0, 8'd5, 1, 0, 32'h0A0000AA);
    run(16'h5AFE, 48'h112233445567, 32'h0A000006, 1'b1, 8'd5, 1, 2, 32'h0A0000AB);
    run(16'h5AFE, 48'h112233445568, 32'h0A000007, 1'b1, 8'd6, 0, 0, 32'h0A0000AC);
    run(16'h5AFE, 48'h112233445569, 32'h0A000008, 1'b1, 8'd6, 2, 3, 32'h0A0000AD);
    run(16'h5AFF, 48'h11223344556A, 32'h0A000009, 1'b0, 8'd4, 1, 1, 32'h0A0000AE);
    run(16'h0000, 48'h11223344556B, 32'h0A00000A, 1'b0, 8'd4, 0, 0, 32'h0A0000AF);
    run(16'h5AFE, 48'h11223344556C, 32'h0A00000B, 1'b1, 8'd7, 1, 7, 32'h0A0000B0);
    run(16'h1234, 48'h11223344556D, 32'h0A00000C, 1'b1, 8'd3, 3, 2, 32'h0A0000B1);
    run(16'h5AFE, 48'h11223344556E, 32'h0A00000D, 1'b1, 8'd0, 0, 0, 32'h0A0000B2);
    run(16'hA5FE, 48'h11223344556F, 32'h0A00000E, 1'b1, 8'd2, 2, 0, 32'h0A0000B3);
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [15:0] s = ($urandom % 2) ? 16'h5AFE : 16'($urandom);
      logic [CW-1:0] l = CW'($urandom % 16);
      int md = int'($urandom % 4);
      int kk = int'($urandom % (int'(l) + 1));
      run(s, {16'($urandom), 32'($urandom)}, 32'($urandom), 1'($urandom), l, md, kk,
          32'($urandom));
    end
    if (seed == 0) checks = checks + 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule